// File: doc/BRIEF.md
# Interrupt Controller Command Front End

This block is the programming front end of one eight-input interrupt controller. Software drives a byte-wide bus with a single address bit that chooses between a command address and a data address. Writing a setup byte to the command address starts a short fixed sequence of data-address writes. That sequence loads the vector base, an optional cascade byte and an optional mode byte. Once the sequence has finished, further command-address writes are operation bytes. These either end in-service interrupts or choose which status byte a command-address read returns.

The block owns the mask and in-service registers. It gives the mask, the vector base and a one-cycle end-of-interrupt clear vector to a separate request and priority core. That core marks interrupts as in service through a set vector. All state changes happen at the clock edge that ends a strobed cycle. Reads are combinational.

Top module: `picf_cmd_front`

## Requirements
- R1: After reset the sequencer waits for a setup byte (`ready_o`=0). Mask, vector base, cascade, mode, last end-of-interrupt command, in-service bits and `cmd_err_o` are all zero, and `read_ctl_o` is 0x02.
- R2: A command-address write (`addr_i`=0) with bit 4 set is a setup byte in every state. It records bit 1 as the single flag and bit 0 as the mode-byte-needed flag, makes the sequencer wait for the vector base and clears `cmd_err_o`.
- R3: A data-address write (`addr_i`=1) while the sequencer waits for the vector base loads `vec_base_o`. The sequencer then waits for the cascade byte if the single flag is 0. If the single flag is 1 it waits for the mode byte when that byte is needed, and otherwise becomes ready.
- R4: A data write that loads the cascade byte moves the sequencer to wait for the mode byte if that byte is needed, and makes it ready otherwise. A data write that loads the mode byte makes it ready.
- R5: A data write while the sequencer waits for a setup byte, or is ready, loads the mask. Data writes that take part in the setup sequence leave the mask unchanged. A data-address read always returns the mask.
- R6: When ready, a command write with bits 4:3 = 00 is stored as the last end-of-interrupt command and one with bits 4:3 = 01 is stored as the read control byte. A command write with bit 4 clear while not ready changes nothing.
- R7: A stored end-of-interrupt command uses bit 7 = R, bit 6 = SL, bit 5 = EOI and bits 2:0 = level. When R=0, SL=1 and EOI=1, `eoi_clr_o` is the one-hot vector for the level during the write cycle, and that in-service bit is clear after the edge.
- R8: With R=0, SL=0 and EOI=1, `eoi_clr_o` selects only the lowest-numbered in-service bit that is set. If no bit is set, nothing is cleared.
- R9: The combinations R=1,SL=1,EOI=0 and R=0,SL=1,EOI=0 change nothing. Every other combination not in R7 or R8 sets `cmd_err_o`, which stays set until the next setup byte.
- R10: A command-address read returns the request inputs when `read_ctl_o` bits 1:0 = 10 and the in-service bits when they are 11. For the other two values it returns 0x00.
- R11: `insvc_set_i` sets in-service bits at the next edge. When the same bit is cleared by an end-of-interrupt in the same cycle, the set wins.
- R12: `rdata_o` follows the selected register in the cycle `rd_i` is high and is 0x00 otherwise. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 1 | 0 selects the command address, 1 the data address |
| wr_i | input | 1 | Write strobe, one byte per cycle |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| req_i | input | 8 | Request bits from the priority core, returned on status reads |
| insvc_set_i | input | 8 | In-service set vector from the priority core |
| mask_o | output | 8 | Interrupt mask |
| vec_base_o | output | 8 | Vector base |
| casc_o | output | 8 | Cascade byte |
| mode_o | output | 8 | Mode byte |
| insvc_o | output | 8 | In-service bits |
| eoi_clr_o | output | 8 | In-service clear vector for this cycle |
| ready_o | output | 1 | Setup sequence complete |
| cmd_err_o | output | 1 | Unsupported end-of-interrupt command seen |
| last_eoi_cmd_o | output | 8 | Last end-of-interrupt command byte |
| read_ctl_o | output | 8 | Last read control byte |

## Verification
The assertions rely on the single address bit, so a command write and a data write never happen in the same cycle. They also rely on `insvc_set_i` being sampled only at clock edges, so it may carry any pattern, including bits that an end-of-interrupt clears in the same cycle. The stimulus changes inputs only at falling edges and holds each value for a full cycle. Command bytes are chosen so that bits 4:3 fall where the intended decode needs them: 0x0B, 0x0A and 0x08 select status reads, and 0x20, 0x65 and 0xA0 are end-of-interrupt forms. This means no operation byte is taken for a setup byte by accident.

// File: rtl/picf_pkg.sv
package picf_pkg;

   typedef enum logic [2:0] {
      SEQ_IDLE      = 3'd0,
      SEQ_WANT_BASE = 3'd1,
      SEQ_WANT_CASC = 3'd2,
      SEQ_WANT_MODE = 3'd3,
      SEQ_RUN       = 3'd4
   } seq_state_e;

   // command byte field positions (decoded by neighbouring logic)
   localparam int unsigned CW_BIT_R     = 7;
   localparam int unsigned CW_BIT_SL    = 6;
   localparam int unsigned CW_BIT_EOI   = 5;
   localparam int unsigned CW_BIT_SETUP = 4;
   localparam int unsigned CW_BIT_SEL   = 3;

   // setup byte flags
   localparam int unsigned SU_BIT_SNGL  = 1;
   localparam int unsigned SU_BIT_NEED4 = 0;

   // {R,SL,EOI} action codes
   localparam logic [2:0] ACT_SPEC = 3'b011;
   localparam logic [2:0] ACT_LOW  = 3'b001;
   localparam logic [2:0] ACT_PRIO = 3'b110;
   localparam logic [2:0] ACT_NOP  = 3'b010;

   // read select codes in the read control byte
   localparam logic [1:0] RSEL_REQ   = 2'b10;
   localparam logic [1:0] RSEL_INSVC = 2'b11;

endpackage

// File: rtl/picf_setup_seq.sv
module picf_setup_seq
   import picf_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LEVELS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr_i,
   input  logic              data_wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output seq_state_e        state_o,
   output logic              setup_hit_o,
   output logic [LEVELS-1:0] mask_o,
   output logic [DATA_W-1:0] base_o,
   output logic [DATA_W-1:0] casc_o,
   output logic [DATA_W-1:0] mode_o
);

   seq_state_e        st_q;
   logic              sngl_q;
   logic              need4_q;
   logic [LEVELS-1:0] mask_q;
   logic [DATA_W-1:0] base_q;
   logic [DATA_W-1:0] casc_q;
   logic [DATA_W-1:0] mode_q;

   assign setup_hit_o = cmd_wr_i & wdata_i[CW_BIT_SETUP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SEQ_IDLE;
         sngl_q  <= 1'b0;
         need4_q <= 1'b0;
         mask_q  <= '0;
         base_q  <= '0;
         casc_q  <= '0;
         mode_q  <= '0;
      end else if (setup_hit_o) begin
         sngl_q  <= wdata_i[SU_BIT_SNGL];
         need4_q <= wdata_i[SU_BIT_NEED4];
         st_q    <= SEQ_WANT_BASE;
      end else if (data_wr_i) begin
         case (st_q)
            SEQ_WANT_BASE: begin
               base_q <= wdata_i;
               if (!sngl_q)
                  st_q <= SEQ_WANT_CASC;
               else if (need4_q)
                  st_q <= SEQ_WANT_MODE;
               else
                  st_q <= SEQ_RUN;
            end
            SEQ_WANT_CASC: begin
               casc_q <= wdata_i;
               st_q   <= need4_q ? SEQ_WANT_MODE : SEQ_RUN;
            end
            SEQ_WANT_MODE: begin
               mode_q <= wdata_i;
               st_q   <= SEQ_RUN;
            end
            default: mask_q <= wdata_i[LEVELS-1:0];
         endcase
      end
   end

   assign state_o = st_q;
   assign mask_o  = mask_q;
   assign base_o  = base_q;
   assign casc_o  = casc_q;
   assign mode_o  = mode_q;

   p_setup_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr_i && wdata_i[CW_BIT_SETUP]) |=> (st_q == SEQ_WANT_BASE));

   p_base_branch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr_i && st_q == SEQ_WANT_BASE && !sngl_q) |=> (st_q == SEQ_WANT_CASC));

   p_casc_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr_i && st_q == SEQ_WANT_CASC) |=>
         (st_q == (need4_q ? SEQ_WANT_MODE : SEQ_RUN)));

   p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr_i && (st_q == SEQ_WANT_BASE || st_q == SEQ_WANT_CASC ||
                     st_q == SEQ_WANT_MODE)) |=> $stable(mask_q));

endmodule

// File: rtl/picf_op_decode.sv
module picf_op_decode
   import picf_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LEVELS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr_i,
   input  logic              run_i,
   input  logic              setup_hit_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [LEVELS-1:0] insvc_i,
   output logic [LEVELS-1:0] eoi_clr_o,
   output logic              err_o,
   output logic [DATA_W-1:0] last_cmd_o,
   output logic [DATA_W-1:0] read_ctl_o
);

   localparam int unsigned LVL_W   = $clog2(LEVELS);
   localparam logic [DATA_W-1:0] RCTL_RST = DATA_W'(2);

   logic              op_wr, eoi_wr, sel_wr;
   logic [2:0]        act;
   logic              is_spec, is_low, is_bad;
   logic [LEVELS-1:0] spec_mask;
   logic [LEVELS-1:0] low_mask;
   logic [LEVELS:0]   seen;
   logic [DATA_W-1:0] last_q, rctl_q;
   logic              err_q;

   assign op_wr  = cmd_wr_i & run_i & ~wdata_i[CW_BIT_SETUP];
   assign eoi_wr = op_wr & ~wdata_i[CW_BIT_SEL];
   assign sel_wr = op_wr &  wdata_i[CW_BIT_SEL];
   assign act    = {wdata_i[CW_BIT_R], wdata_i[CW_BIT_SL], wdata_i[CW_BIT_EOI]};

   assign is_spec = eoi_wr && (act == ACT_SPEC);
   assign is_low  = eoi_wr && (act == ACT_LOW);
   assign is_bad  = eoi_wr && (act != ACT_SPEC) && (act != ACT_LOW) &&
                    (act != ACT_PRIO) && (act != ACT_NOP);

   // level field decoder
   for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      assign spec_mask[g] = (wdata_i[LVL_W-1:0] == LVL_W'(g));
   end

   // lowest set in-service bit finder
   assign seen[0] = 1'b0;
   for (genvar g = 0; g < LEVELS; g++) begin : g_low
      assign low_mask[g]  = insvc_i[g] & ~seen[g];
      assign seen[g+1]    = seen[g] | insvc_i[g];
   end

   assign eoi_clr_o = is_spec ? spec_mask :
                      is_low  ? low_mask  : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= '0;
         rctl_q <= RCTL_RST;
         err_q  <= 1'b0;
      end else begin
         if (eoi_wr) last_q <= wdata_i;
         if (sel_wr) rctl_q <= wdata_i;
         if (setup_hit_i)
            err_q <= 1'b0;
         else if (is_bad)
            err_q <= 1'b1;
      end
   end

   assign err_o      = err_q;
   assign last_cmd_o = last_q;
   assign read_ctl_o = rctl_q;

   p_eoi_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(eoi_clr_o));

   p_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr_i && run_i && wdata_i[CW_BIT_SETUP:CW_BIT_SEL] == 2'b00 &&
       !wdata_i[CW_BIT_R] && !wdata_i[CW_BIT_SL] && wdata_i[CW_BIT_EOI])
      |-> (eoi_clr_o == (insvc_i & (~insvc_i + 1'b1))));

   p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr_i && run_i && wdata_i[CW_BIT_SETUP:CW_BIT_SEL] == 2'b00 &&
       wdata_i[CW_BIT_R] && !wdata_i[CW_BIT_SL]) |=> err_o);

   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr_i && wdata_i[CW_BIT_SETUP:CW_BIT_SEL] == 2'b00 &&
       wdata_i[CW_BIT_SL] && !wdata_i[CW_BIT_EOI]) |-> (eoi_clr_o == '0));

   p_err_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      setup_hit_i |=> !err_o);

endmodule

// File: rtl/picf_insvc_bank.sv
module picf_insvc_bank #(
   parameter int unsigned LEVELS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEVELS-1:0] set_i,
   input  logic [LEVELS-1:0] clr_i,
   output logic [LEVELS-1:0] insvc_o
);

   logic [LEVELS-1:0] insvc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         insvc_q <= '0;
      else
         insvc_q <= (insvc_q & ~clr_i) | set_i;
   end

   assign insvc_o = insvc_q;

   p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((insvc_q & $past(set_i)) == $past(set_i)));

   p_clear_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i & ~set_i) != '0) |=> ((insvc_q & $past(clr_i & ~set_i)) == '0));

endmodule

// File: rtl/picf_cmd_front.sv
module picf_cmd_front
   import picf_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LEVELS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [LEVELS-1:0] req_i,
   input  logic [LEVELS-1:0] insvc_set_i,
   output logic [LEVELS-1:0] mask_o,
   output logic [DATA_W-1:0] vec_base_o,
   output logic [DATA_W-1:0] casc_o,
   output logic [DATA_W-1:0] mode_o,
   output logic [LEVELS-1:0] insvc_o,
   output logic [LEVELS-1:0] eoi_clr_o,
   output logic              ready_o,
   output logic              cmd_err_o,
   output logic [DATA_W-1:0] last_eoi_cmd_o,
   output logic [DATA_W-1:0] read_ctl_o
);

   if (DATA_W != 8) begin : g_bad_width
      $error("picf_cmd_front: command fields need an 8-bit bus");
   end
   if (LEVELS != 2 && LEVELS != 4 && LEVELS != 8) begin : g_bad_levels
      $error("picf_cmd_front: LEVELS must be 2, 4 or 8");
   end

   logic       cmd_wr, data_wr, setup_hit;
   seq_state_e state;

   assign cmd_wr  = wr_i & ~addr_i;
   assign data_wr = wr_i &  addr_i;

   picf_setup_seq #(.DATA_W(DATA_W), .LEVELS(LEVELS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_wr_i   (cmd_wr),
      .data_wr_i  (data_wr),
      .wdata_i    (wdata_i),
      .state_o    (state),
      .setup_hit_o(setup_hit),
      .mask_o     (mask_o),
      .base_o     (vec_base_o),
      .casc_o     (casc_o),
      .mode_o     (mode_o)
   );

   assign ready_o = (state == SEQ_RUN);

   picf_op_decode #(.DATA_W(DATA_W), .LEVELS(LEVELS)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_wr_i   (cmd_wr),
      .run_i      (ready_o),
      .setup_hit_i(setup_hit),
      .wdata_i    (wdata_i),
      .insvc_i    (insvc_o),
      .eoi_clr_o  (eoi_clr_o),
      .err_o      (cmd_err_o),
      .last_cmd_o (last_eoi_cmd_o),
      .read_ctl_o (read_ctl_o)
   );

   picf_insvc_bank #(.LEVELS(LEVELS)) u_isb (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (insvc_set_i),
      .clr_i  (eoi_clr_o),
      .insvc_o(insvc_o)
   );

   always_comb begin
      rdata_o = '0;
      if (rd_i) begin
         if (addr_i)
            rdata_o = DATA_W'(mask_o);
         else begin
            case (read_ctl_o[1:0])
               RSEL_REQ:   rdata_o = DATA_W'(req_i);
               RSEL_INSVC: rdata_o = DATA_W'(insvc_o);
               default:    rdata_o = '0;
            endcase
         end
      end
   end

   p_rd_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && addr_i) |-> (rdata_o == DATA_W'(mask_o)));

   p_rd_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |-> (rdata_o == '0));

   p_op_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !wdata_i[CW_BIT_SETUP] && !ready_o) |=>
         ($stable(last_eoi_cmd_o) && $stable(read_ctl_o)));

endmodule

// File: tb/test_picf_cmd_front.sv
`timescale 1ns/1ps
module test_picf_cmd_front;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [7:0] wdata = '0, req = '0, iset = '0;

   logic [7:0] rdata, mask, vbase, casc, mode, insvc, eclr, lastc, rctl;
   logic       ready, err;

   always #2 clk = ~clk;

   picf_cmd_front i_picf_cmd_front (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
      .wdata_i(wdata), .rdata_o(rdata), .req_i(req), .insvc_set_i(iset),
      .mask_o(mask), .vec_base_o(vbase), .casc_o(casc), .mode_o(mode),
      .insvc_o(insvc), .eoi_clr_o(eclr), .ready_o(ready), .cmd_err_o(err),
      .last_eoi_cmd_o(lastc), .read_ctl_o(rctl)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";

   // reference model state: 0 idle, 1 base, 2 cascade, 3 mode, 4 ready
   int         m_st = 0;
   logic       m_sngl = 0, m_need4 = 0, m_err = 0;
   logic [7:0] m_base = 0, m_casc = 0, m_mode = 0, m_mask = 0;
   logic [7:0] m_last = 0, m_rctl = 8'h02, m_insvc = 0;

   function automatic logic [7:0] m_eoi();
      logic [2:0] a;
      if (wr && !addr && m_st == 4 && wdata[4:3] == 2'b00) begin
         a = wdata[7:5];
         if (a == 3'b011) return 8'(1) << wdata[2:0];
         if (a == 3'b001)
            for (int i = 0; i < 8; i++)
               if (m_insvc[i]) return 8'(1) << i;
      end
      return 8'h00;
   endfunction

   function automatic logic [7:0] m_rdata();
      if (!rd) return 8'h00;
      if (addr) return m_mask;
      if (m_rctl[1:0] == 2'b10) return req;
      if (m_rctl[1:0] == 2'b11) return m_insvc;
      return 8'h00;
   endfunction

   task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("rdata", rdata, m_rdata());
      chk("eoi_clr", eclr, m_eoi());
      chk("mask", mask, m_mask);
      chk("vec_base", vbase, m_base);
      chk("casc", casc, m_casc);
      chk("mode", mode, m_mode);
      chk("insvc", insvc, m_insvc);
      chk("last_eoi_cmd", lastc, m_last);
      chk("read_ctl", rctl, m_rctl);
      chk("ready", {7'd0, ready}, {7'd0, m_st == 4});
      chk("cmd_err", {7'd0, err}, {7'd0, m_err});
   endtask

   task automatic model_step();
      logic [7:0] clr;
      logic [2:0] a;
      clr = m_eoi();
      if (wr) begin
         if (!addr) begin
            if (wdata[4]) begin
               m_sngl = wdata[1]; m_need4 = wdata[0]; m_st = 1; m_err = 0;
            end else if (m_st == 4) begin
               if (!wdata[3]) begin
                  m_last = wdata;
                  a = wdata[7:5];
                  if (a != 3'b011 && a != 3'b001 && a != 3'b110 && a != 3'b010)
                     m_err = 1;
               end else
                  m_rctl = wdata;
            end
         end else begin
            case (m_st)
               1: begin
                  m_base = wdata;
                  m_st = !m_sngl ? 2 : (m_need4 ? 3 : 4);
               end
               2: begin m_casc = wdata; m_st = m_need4 ? 3 : 4; end
               3: begin m_mode = wdata; m_st = 4; end
               default: m_mask = wdata;
            endcase
         end
      end
      m_insvc = (m_insvc & ~clr) | iset;
   endtask

   task automatic cyc(input logic a, input logic w, input logic r,
                      input logic [7:0] d, input logic [7:0] s);
      @(negedge clk);
      addr = a; wr = w; rd = r; wdata = d; iset = s;
      #1 compare_all();
      @(posedge clk);
      model_step();
   endtask

   task automatic idle();          cyc(0, 0, 0, 8'h00, 8'h00); endtask
   task automatic wcmd(input logic [7:0] d); cyc(0, 1, 0, d, 8'h00); endtask
   task automatic wdat(input logic [7:0] d); cyc(1, 1, 0, d, 8'h00); endtask
   task automatic rcmd();          cyc(0, 0, 1, 8'h00, 8'h00); endtask
   task automatic rdat();          cyc(1, 0, 1, 8'h00, 8'h00); endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #400000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      cur_req = "R1";  idle(); idle();
      cur_req = "R10"; req = 8'h5A; rcmd();
      cur_req = "R5";  wdat(8'hA5); rdat();
      cur_req = "R6";  wcmd(8'h0B); rcmd();
      cur_req = "R2";  wcmd(8'h11);
      cur_req = "R3";  wdat(8'h20);
      cur_req = "R4";  wdat(8'h04); wdat(8'h01); rdat();
      cur_req = "R2";  wcmd(8'h11); wcmd(8'h13);
      cur_req = "R3";  wdat(8'h40); wdat(8'h03);
      cur_req = "R3";  wcmd(8'h12); wdat(8'h08); idle();
      cur_req = "R5";  wdat(8'h3C); rdat();
      cur_req = "R11"; cyc(0, 0, 0, 8'h00, 8'h2C); idle();
      cur_req = "R10"; wcmd(8'h0B); rcmd();
      cur_req = "R8";  wcmd(8'h20); wcmd(8'h20); rcmd();
      cur_req = "R7";  wcmd(8'h65); wcmd(8'h61); rcmd();
      cur_req = "R8";  wcmd(8'h20); idle();
      cur_req = "R9";  cyc(0, 0, 0, 8'h00, 8'h81); wcmd(8'hC3); wcmd(8'h43); rcmd();
      cur_req = "R9";  wcmd(8'hA0); idle(); wcmd(8'h00); wcmd(8'h20);
      cur_req = "R2";  wcmd(8'h13); wdat(8'h50); wdat(8'h01); idle();
      cur_req = "R11"; cyc(0, 1, 0, 8'h67, 8'h80); rcmd();
      cur_req = "R12"; cyc(1, 1, 1, 8'hFF, 8'h00); rdat(); cyc(0, 1, 1, 8'h0A, 8'h00);
      cur_req = "R10"; req = 8'hC3; rcmd(); wcmd(8'h08); rcmd(); wcmd(8'h0B); rcmd();
      cur_req = "R6";  wcmd(8'h43); wcmd(8'h09); rcmd(); idle();

      summary();
      $finish;
   end

endmodule